// File: doc/BRIEF.md
# Software Interrupt Target Dispatcher

This block turns one core's write to a software-interrupt trigger register into per-core pending-set strobes. The 32-bit write value holds a 4-bit interrupt number, a 2-bit routing selector and an 8-bit explicit core list. The index of the writing core comes in on its own input with the write strobe. The routing selector chooses the target set. It can be the explicit list, every implemented core except the writer, or the writer alone. The fourth selector value is refused.

The result is registered and appears one cycle after the write. It is a core mask and the interrupt number, qualified by a valid pulse that lasts one cycle. A write that resolves to no cores gives no pulse. Pending storage, arbitration and tracking of the source core belong to the consumer.

Top module: `sgi_route_top`

## Requirements
- R1: After reset, `tgt_valid` is 0 and `tgt_mask` is all zeros.
- R2: With selector bits [25:24] = 0, the target mask is write bits [23:16] ANDed with the mask of implemented cores (`NUM_CORES` low bits).
- R3: With selector = 1, the target mask is every implemented core except the core given by `wr_core`.
- R4: With selector = 2, the target mask has only bit `wr_core` set.
- R5: Selector = 3 produces no pulse, and the outputs stay as they were.
- R6: A write whose target mask resolves to zero produces no pulse. Examples are selector 0 with no implemented core listed, or selector 1 with one core.
- R7: A valid write at edge N makes `tgt_valid` high for exactly the cycle after edge N+1's predecessor. In other words it is visible after edge N and cleared after edge N+1 unless another valid write follows. `tgt_id` equals write bits [3:0].
- R8: Whenever `tgt_valid` is high, `tgt_mask` is non-zero and has no bit set at or above `NUM_CORES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the trigger register |
| wr_data | input | 32 | Written value |
| wr_core | input | CORE_W | Index of the writing core |
| tgt_valid | output | 1 | One-cycle pulse: strobes below are valid |
| tgt_mask | output | MAX_CORES | Per-core pending-set vector |
| tgt_id | output | ID_W | Software interrupt number |

## Verification
The assertions assume that `wr_core` names an implemented core whenever `wr_en` is high. The stimulus only ever drives core indices below `NUM_CORES`. The assertions also take the registered outputs to depend only on the previous cycle's write. For that reason the bench changes inputs only at negative clock edges, and it holds `wr_en` low between scenarios, so each pulse can be traced to a single write.

// File: rtl/sgi_route_pkg.sv
package sgi_route_pkg;
   typedef enum logic [1:0] {
      SEL_LIST   = 2'd0,
      SEL_OTHERS = 2'd1,
      SEL_SELF   = 2'd2,
      SEL_RSVD   = 2'd3
   } sel_e;
endpackage

// File: rtl/sgi_route_decode.sv
module sgi_route_decode
   import sgi_route_pkg::*;
#(
   parameter int MAX_CORES = 8,
   parameter int NUM_CORES = 4,
   parameter int CORE_W    = 3,
   parameter int ID_W      = 4
) (
   input  logic [31:0]          wr_data,
   input  logic [CORE_W-1:0]    wr_core,
   output logic [MAX_CORES-1:0] mask_o,
   output logic [ID_W-1:0]      id_o,
   output logic                 ok_o
);
   localparam logic [MAX_CORES-1:0] IMPL = MAX_CORES'((64'd1 << NUM_CORES) - 64'd1);

   sel_e                 sel;
   logic [MAX_CORES-1:0] self_bit;

   assign sel      = sel_e'(wr_data[25:24]);
   assign self_bit = MAX_CORES'(1) << wr_core;
   assign id_o     = wr_data[ID_W-1:0];

   always_comb begin
      unique case (sel)
         SEL_LIST:   mask_o = wr_data[16 +: MAX_CORES] & IMPL;
         SEL_OTHERS: mask_o = IMPL & ~self_bit;
         SEL_SELF:   mask_o = self_bit & IMPL;
         default:    mask_o = '0;
      endcase
   end

   assign ok_o = (sel != SEL_RSVD) && (mask_o != '0);
endmodule

// File: rtl/sgi_route_out.sv
module sgi_route_out #(
   parameter int MAX_CORES = 8,
   parameter int NUM_CORES = 4,
   parameter int ID_W      = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [MAX_CORES-1:0] mask_i,
   input  logic [ID_W-1:0]      id_i,
   output logic                 valid_q,
   output logic [MAX_CORES-1:0] mask_q,
   output logic [ID_W-1:0]      id_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         mask_q  <= '0;
         id_q    <= '0;
      end else begin
         valid_q <= load;
         if (load) begin
            mask_q <= mask_i;
            id_q   <= id_i;
         end
      end
   end

   assert_valid_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> (mask_q != '0));
   assert_pulse_from_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> valid_q);
   assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(mask_q) && $stable(id_q));
   if (NUM_CORES < MAX_CORES) begin : g_hi_chk
      assert_no_unimpl_R8: assert property (@(posedge clk) disable iff (!rst_n)
         mask_q[MAX_CORES-1:NUM_CORES] == '0);
   end
endmodule

// File: rtl/sgi_route_top.sv
module sgi_route_top #(
   parameter int MAX_CORES = 8,
   parameter int NUM_CORES = 4,
   parameter int ID_W      = 4,
   parameter int CORE_W    = (MAX_CORES > 1) ? $clog2(MAX_CORES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [31:0]          wr_data,
   input  logic [CORE_W-1:0]    wr_core,
   output logic                 tgt_valid,
   output logic [MAX_CORES-1:0] tgt_mask,
   output logic [ID_W-1:0]      tgt_id
);
   initial begin
      assert (MAX_CORES >= 1 && MAX_CORES <= 8) else $error("MAX_CORES out of range");
      assert (NUM_CORES >= 1 && NUM_CORES <= MAX_CORES) else $error("NUM_CORES out of range");
      assert (ID_W >= 1 && ID_W <= 16) else $error("ID_W out of range");
   end

   logic [MAX_CORES-1:0] dec_mask;
   logic [ID_W-1:0]      dec_id;
   logic                 dec_ok;

   sgi_route_decode #(.MAX_CORES(MAX_CORES), .NUM_CORES(NUM_CORES),
                      .CORE_W(CORE_W), .ID_W(ID_W)) u_dec (
      .wr_data(wr_data), .wr_core(wr_core),
      .mask_o(dec_mask), .id_o(dec_id), .ok_o(dec_ok));

   sgi_route_out #(.MAX_CORES(MAX_CORES), .NUM_CORES(NUM_CORES), .ID_W(ID_W)) u_out (
      .clk(clk), .rst_n(rst_n), .load(wr_en && dec_ok),
      .mask_i(dec_mask), .id_i(dec_id),
      .valid_q(tgt_valid), .mask_q(tgt_mask), .id_q(tgt_id));

   assert_rsvd_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[25:24] == 2'd3) |=> !tgt_valid);
   assert_self_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[25:24] == 2'd2 && 32'(wr_core) < NUM_CORES) |=> tgt_valid && $onehot0(tgt_mask));
   assert_no_write_no_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !tgt_valid);
endmodule

// File: tb/tb_sgi_route_top.sv
module tb_sgi_route_top;
   localparam int CLK_PERIOD = 10;
   localparam int MAXC = 8;
   localparam int NC = 4;

   logic clk = 0, rst_n = 0, wr_en = 0;
   logic [31:0] wr_data = '0;
   logic [2:0] wr_core = '0;
   logic tgt_valid;
   logic [MAXC-1:0] tgt_mask;
   logic [3:0] tgt_id;
   int total = 0, bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sgi_route_top #(.MAX_CORES(MAXC), .NUM_CORES(NC)) dut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] word(input int sel, input logic [7:0] lst, input int id);
      return {6'b0, 2'(sel), lst, 12'b0, 4'(id)};
   endfunction

   // drive at negedge; after the following posedge sample at next negedge
   task automatic do_write(input logic [31:0] d, input int core);
      @(negedge clk);
      wr_en = 1; wr_data = d; wr_core = 3'(core);
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic expect_pulse(input string req, input logic [7:0] m, input int id);
      chk(req, 32'(tgt_valid), 1);
      chk(req, 32'(tgt_mask), 32'(m));
      chk(req, 32'(tgt_id), 32'(id));
      @(negedge clk);
      chk({req, " pulse width"}, 32'(tgt_valid), 0);
   endtask

   task automatic t_reset;
      chk("R1 valid", 32'(tgt_valid), 0);
      chk("R1 mask", 32'(tgt_mask), 0);
   endtask

   task automatic t_list;
      do_write(word(0, 8'hF5, 7), 1); expect_pulse("R2", 8'h05, 7);
      do_write(word(0, 8'h0A, 3), 3); expect_pulse("R2", 8'h0A, 3);
   endtask

   task automatic t_others;
      do_write(word(1, 8'hFF, 9), 2); expect_pulse("R3", 8'h0B, 9);
      do_write(word(1, 8'h00, 0), 0); expect_pulse("R3", 8'h0E, 0);
   endtask

   task automatic t_self;
      do_write(word(2, 8'h01, 15), 3); expect_pulse("R4", 8'h08, 15);
      do_write(word(2, 8'hFF, 4), 0); expect_pulse("R4 id R7", 8'h01, 4);
   endtask

   task automatic t_rsvd;
      do_write(word(3, 8'hFF, 2), 1);
      chk("R5 valid", 32'(tgt_valid), 0);
      chk("R5 mask held", 32'(tgt_mask), 32'(8'h01));
      chk("R5 id held", 32'(tgt_id), 4);
   endtask

   task automatic t_empty;
      do_write(word(0, 8'hF0, 6), 0);
      chk("R6 unimpl list", 32'(tgt_valid), 0);
      do_write(word(0, 8'h00, 6), 0);
      chk("R6 empty list", 32'(tgt_valid), 0);
   endtask

   task automatic t_back2back;
      @(negedge clk);
      wr_en = 1; wr_data = word(2, 0, 1); wr_core = 3'd1;
      @(negedge clk);
      chk("R7 first", 32'(tgt_mask), 32'(8'h02));
      chk("R7 first v", 32'(tgt_valid), 1);
      wr_data = word(2, 0, 2); wr_core = 3'd2;
      @(negedge clk);
      wr_en = 0;
      chk("R7 second", 32'(tgt_mask), 32'(8'h04));
      chk("R7 second id", 32'(tgt_id), 2);
      chk("R8 valid", 32'(tgt_valid), 1);
      @(negedge clk);
      chk("R7 end", 32'(tgt_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_list();
      t_others();
      t_self();
      t_rsvd();
      t_empty();
      t_back2back();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule